// File: doc/BRIEF.md
# Shared PWM Generator Bank with Per-Pin Routing

The block holds a small pool of PWM waveform generators that a larger set of output pins share. Each generator is set up with three values: a slot length (in base-time strobes), a count of high slots and a count of low slots. It produces a repeating waveform that is high for the high slots and then low for the low slots. Each output pin has its own routing field, which names one generator and turns the pin on. Any number of pins may follow the same generator. The raw generator waveforms also leave the block, so that a serial expander outside can use them.

Software programs the bank through a single-cycle word write port and reads it back through a combinational read port. Timing comes from a single-cycle strobe input, tick_i. New generator values are held in a shadow copy and take effect only when the generator reaches the end of its current period, so the output never shows a half-applied setting. A new routing choice takes effect at once. Turning a pin off is deferred: the pin keeps following its generator until that generator's period ends, and only then does it go low.

Top module: `pwm_gen_bank`

## Requirements
- R1: After reset every pin and generator output is 0 and every address reads 0.
- R2: Addresses 0 and 1 hold the 8-bit slot-length fields. Generator n sits in word n/4, bits [8*(n%4)+7 : 8*(n%4)]. A written value reads back unchanged.
- R3: Addresses 2 to 5 hold the phase counts. Generator n sits in word 2+n/2. For even n the high count is in [7:0] and the low count in [15:8]. For odd n the high count is in [23:16] and the low count in [31:24].
- R4: Addresses 6 and 7 hold the pin routing nibbles. Pin p sits in word 6+p/8, bits [4*(p%8)+3 : 4*(p%8)]. Nibble bits [2:0] pick the generator and nibble bit 3 turns the pin on.
- R5: Addresses 8 to 15 read 0, and a write to any of them changes no state.
- R6: A period lasts high+low slots, and each slot lasts a number of tick_i strobes equal to the slot length (0 counts as 1). The waveform is high in the first high-count slots of the period and low in the rest. A zero total gives a one-slot period that stays low.
- R7: A high count of 255 with a low count of 0 gives a constant high. A high count of 0 gives a constant low.
- R8: Values written to a generator are used only from the end of the period in progress.
- R9: A pin that is turned on drives the waveform of its selected generator. Several pins may share one generator, and a change of selection takes effect in the cycle after the write.
- R10: When a pin is turned off, it keeps following its selected generator until that generator's period ends, and then drives 0.
- R11: A pin that has never been turned on, or that was turned off and has been released, drives 0.
- R12: gen_wave_o carries each generator's waveform, whether or not any pin selects that generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Single-cycle base-time strobe |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 4 | Write word address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read word address |
| rd_data_o | output | 32 | Read data (combinational) |
| pin_o | output | 16 | Pin levels |
| gen_wave_o | output | 8 | Raw generator waveforms |

## Verification
The assertions check on every cycle that a generator's active setting changes only at the end of a period, and that its slot index stays inside the period. They also check that a pin is released only when its generator signals a period end, and that a write to an unused address leaves all state unchanged. Only the bench's scenarios can show the correct field placement, the exact high and low slot counts under uneven strobe patterns, and the deferred switch-off of a pin that shares a long full-duty generator. The bench covers these with a cycle-by-cycle reference model and targeted readback and timing checks.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int FLD_W  = 8;
  localparam int WORD_W = 32;
  localparam int NIB_W  = 4;
  localparam int SEL_W  = 3;

  localparam int CYC_PER_WORD = WORD_W / FLD_W;
  localparam int CNT_PER_WORD = WORD_W / (2 * FLD_W);
  localparam int MAP_PER_WORD = WORD_W / NIB_W;

  typedef struct packed {
    logic [FLD_W-1:0] cyc;
    logic [FLD_W-1:0] hi;
    logic [FLD_W-1:0] lo;
  } gen_cfg_t;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } pin_map_t;
endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_GEN = 8,
  parameter int NUM_PIN = 16,
  parameter int ADDR_W  = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [WORD_W-1:0]             wr_data_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [WORD_W-1:0]             rd_data_o,
  output gen_cfg_t [NUM_GEN-1:0]        cfg_o,
  output pin_map_t [NUM_PIN-1:0]        map_o
);
  localparam int CYC_BASE = 0;
  localparam int CNT_BASE = CYC_BASE + NUM_GEN / CYC_PER_WORD;
  localparam int MAP_BASE = CNT_BASE + NUM_GEN / CNT_PER_WORD;
  localparam int MAP_END  = MAP_BASE + NUM_PIN / MAP_PER_WORD;

  gen_cfg_t [NUM_GEN-1:0] cfg_q;
  pin_map_t [NUM_PIN-1:0] map_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      map_q <= '0;
    end else if (wr_en_i) begin
      for (int g = 0; g < NUM_GEN; g++) begin
        if (wr_addr_i == ADDR_W'(CYC_BASE + g / CYC_PER_WORD))
          cfg_q[g].cyc <= wr_data_i[FLD_W*(g%CYC_PER_WORD) +: FLD_W];
        if (wr_addr_i == ADDR_W'(CNT_BASE + g / CNT_PER_WORD)) begin
          cfg_q[g].hi <= wr_data_i[2*FLD_W*(g%CNT_PER_WORD) +: FLD_W];
          cfg_q[g].lo <= wr_data_i[2*FLD_W*(g%CNT_PER_WORD)+FLD_W +: FLD_W];
        end
      end
      for (int p = 0; p < NUM_PIN; p++) begin
        if (wr_addr_i == ADDR_W'(MAP_BASE + p / MAP_PER_WORD))
          map_q[p] <= wr_data_i[NIB_W*(p%MAP_PER_WORD) +: NIB_W];
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int g = 0; g < NUM_GEN; g++) begin
      if (rd_addr_i == ADDR_W'(CYC_BASE + g / CYC_PER_WORD))
        rd_data_o[FLD_W*(g%CYC_PER_WORD) +: FLD_W] = cfg_q[g].cyc;
      if (rd_addr_i == ADDR_W'(CNT_BASE + g / CNT_PER_WORD)) begin
        rd_data_o[2*FLD_W*(g%CNT_PER_WORD) +: FLD_W]       = cfg_q[g].hi;
        rd_data_o[2*FLD_W*(g%CNT_PER_WORD)+FLD_W +: FLD_W] = cfg_q[g].lo;
      end
    end
    for (int p = 0; p < NUM_PIN; p++) begin
      if (rd_addr_i == ADDR_W'(MAP_BASE + p / MAP_PER_WORD))
        rd_data_o[NIB_W*(p%MAP_PER_WORD) +: NIB_W] = map_q[p];
    end
  end

  assign cfg_o = cfg_q;
  assign map_o = map_q;

  // writes outside the map leave every field untouched
  assert_unmapped_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (int'(wr_addr_i) >= MAP_END)) |=> ($stable(cfg_q) && $stable(map_q)));
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
  import pwm_bank_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  gen_cfg_t cfg_i,
  output logic     wave_o,
  output logic     end_o
);
  localparam int SLOT_W = FLD_W + 1;

  gen_cfg_t          act_q;
  logic [FLD_W-1:0]  pre_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W-1:0] len;
  logic              pre_last, slot_last;

  assign len       = {1'b0, act_q.hi} + {1'b0, act_q.lo};
  assign pre_last  = ({1'b0, pre_q} + SLOT_W'(1)) >= {1'b0, act_q.cyc};
  assign slot_last = (slot_q + SLOT_W'(1)) >= len;
  assign end_o     = tick_i && pre_last && slot_last;
  assign wave_o    = slot_q < {1'b0, act_q.hi};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      pre_q  <= '0;
      slot_q <= '0;
    end else if (tick_i) begin
      if (pre_last) begin
        pre_q <= '0;
        if (slot_last) begin
          slot_q <= '0;
          act_q  <= cfg_i;   // shadow takes effect only at period end
        end else begin
          slot_q <= slot_q + SLOT_W'(1);
        end
      end else begin
        pre_q <= pre_q + FLD_W'(1);
      end
    end
  end

  assert_cfg_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !end_o |=> $stable(act_q));
  assert_slot_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == '0) || (slot_q < len));
  assert_full_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q.hi == '1 && act_q.lo == '0) |-> wave_o);
endmodule

// File: rtl/pwm_pin_sel.sv
module pwm_pin_sel
  import pwm_bank_pkg::*;
#(
  parameter int NUM_GEN = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  pin_map_t           map_i,
  input  logic [NUM_GEN-1:0] wave_i,
  input  logic [NUM_GEN-1:0] end_i,
  output logic               pin_o
);
  logic hold_q;

  // hold keeps a switched-off pin live until its generator wraps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hold_q <= 1'b0;
    else if (map_i.en)          hold_q <= 1'b1;
    else if (end_i[map_i.sel])  hold_q <= 1'b0;
  end

  assign pin_o = (map_i.en | hold_q) & wave_i[map_i.sel];

  assert_release_at_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_q) |-> $past(end_i[map_i.sel]));
  assert_quiet_after_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!map_i.en && $past(!map_i.en && end_i[map_i.sel])) |-> !pin_o);
endmodule

// File: rtl/pwm_gen_bank.sv
module pwm_gen_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_GEN = 8,
  parameter int NUM_PIN = 16,
  parameter int ADDR_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [31:0]        wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [31:0]        rd_data_o,
  output logic [NUM_PIN-1:0] pin_o,
  output logic [NUM_GEN-1:0] gen_wave_o
);
  gen_cfg_t [NUM_GEN-1:0] cfg;
  pin_map_t [NUM_PIN-1:0] map;
  logic     [NUM_GEN-1:0] gen_end;

  pwm_cfg_regs #(.NUM_GEN(NUM_GEN), .NUM_PIN(NUM_PIN), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i, .rd_data_o,
    .cfg_o(cfg), .map_o(map)
  );

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    pwm_wave_gen i_gen (
      .clk_i, .rst_ni, .tick_i, .cfg_i(cfg[g]),
      .wave_o(gen_wave_o[g]), .end_o(gen_end[g])
    );
  end

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    pwm_pin_sel #(.NUM_GEN(NUM_GEN)) i_pin (
      .clk_i, .rst_ni, .map_i(map[p]), .wave_i(gen_wave_o), .end_i(gen_end),
      .pin_o(pin_o[p])
    );
  end

  assert_pin_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pin_o) |-> (|gen_wave_o));
endmodule

// File: tb/test_pwm_gen_bank.sv
module test_pwm_gen_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [15:0] pin_o;
  logic [7:0]  gen_wave_o;

  pwm_gen_bank i_pwm_gen_bank (.*);

  always #4 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  bit tick_all = 0, live = 0;

  // reference model state
  int m_cyc[8], m_hi[8], m_lo[8];
  int a_cyc[8], a_hi[8], a_lo[8], pre[8], slot[8];
  int m_sel[16];
  bit m_en[16], m_hold[16], m_end[8];

  function automatic bit mwave(int g);
    return slot[g] < a_hi[g];
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < 8; g++) begin
        m_cyc[g]=0; m_hi[g]=0; m_lo[g]=0; a_cyc[g]=0; a_hi[g]=0; a_lo[g]=0; pre[g]=0; slot[g]=0;
      end
      for (int p = 0; p < 16; p++) begin m_sel[p]=0; m_en[p]=0; m_hold[p]=0; end
    end else begin
      for (int g = 0; g < 8; g++)
        m_end[g] = tick_i && (pre[g]+1 >= a_cyc[g]) && (slot[g]+1 >= a_hi[g]+a_lo[g]);
      for (int p = 0; p < 16; p++)
        if (m_en[p]) m_hold[p] = 1; else if (m_end[m_sel[p]]) m_hold[p] = 0;
      for (int g = 0; g < 8; g++) if (tick_i) begin
        if (pre[g]+1 >= a_cyc[g]) begin
          pre[g] = 0;
          if (slot[g]+1 >= a_hi[g]+a_lo[g]) begin
            slot[g]=0; a_cyc[g]=m_cyc[g]; a_hi[g]=m_hi[g]; a_lo[g]=m_lo[g];
          end else slot[g]++;
        end else pre[g]++;
      end
      if (wr_en_i) begin
        for (int g = 0; g < 8; g++) begin
          if (int'(wr_addr_i) == g/4) m_cyc[g] = int'(wr_data_i[8*(g%4) +: 8]);
          if (int'(wr_addr_i) == 2+g/2) begin
            m_hi[g] = int'(wr_data_i[16*(g%2) +: 8]);
            m_lo[g] = int'(wr_data_i[16*(g%2)+8 +: 8]);
          end
        end
        for (int p = 0; p < 16; p++) if (int'(wr_addr_i) == 6+p/8) begin
          m_sel[p] = int'(wr_data_i[4*(p%8) +: 3]);
          m_en[p]  = wr_data_i[4*(p%8)+3];
        end
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) if (live) begin
    logic [7:0] ew;
    logic [15:0] ep;
    for (int g = 0; g < 8; g++) ew[g] = mwave(g);
    for (int p = 0; p < 16; p++) ep[p] = (m_en[p] | m_hold[p]) & mwave(m_sel[p]);
    chk("R6/R7/R8/R12 gen_wave_o", {24'b0, gen_wave_o}, {24'b0, ew});
    chk("R9/R10/R11 pin_o", {16'b0, pin_o}, {16'b0, ep});
  end

  // tick source
  initial begin
    int n = 0;
    forever begin
      @(negedge clk_i);
      tick_i = tick_all ? 1'b1 : ((n % 3) == 0);
      n++;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1; wr_addr_i = 4'(a); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk_i);
    rd_addr_i = 4'(a);
    #1 chk(tag, rd_data_o, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1 reset outputs", {8'b0, pin_o, gen_wave_o}, 32'h0);
    live = 1;
    for (int a = 0; a < 16; a++) rd(a, 32'h0, "R1 reset readback");

    wr(0, 32'h0302_0101); wr(1, 32'h0101_0101);
    rd(0, 32'h0302_0101, "R2 cycle word 0"); rd(1, 32'h0101_0101, "R2 cycle word 1");

    wr(2, 32'h00FF_0203); wr(3, 32'h0500_0401);
    wr(4, 32'h0104_0202); wr(5, 32'h0505_0000);
    rd(2, 32'h00FF_0203, "R3 count word 2"); rd(3, 32'h0500_0401, "R3 count word 3");
    rd(4, 32'h0104_0202, "R3 count word 4"); rd(5, 32'h0505_0000, "R3 count word 5");

    wr(6, 32'hFC7B_A988); wr(7, 32'h0000_000D);
    rd(6, 32'hFC7B_A988, "R4 map word 6"); rd(7, 32'h0000_000D, "R4 map word 7");

    wr(9, 32'hFFFF_FFFF); wr(15, 32'hFFFF_FFFF);
    rd(9, 32'h0, "R5 unmapped read"); rd(0, 32'h0302_0101, "R5 cycle untouched");
    rd(6, 32'hFC7B_A988, "R5 map untouched");

    repeat (600) @(negedge clk_i);
    chk("R7 full high gen1", {31'b0, gen_wave_o[1]}, 32'h1);
    chk("R7 zero high gen3", {31'b0, gen_wave_o[3]}, 32'h0);
    chk("R11 unrouted pins", {16'b0, pin_o & 16'hFE20}, 32'h0);

    tick_all = 1;
    wr(3, 32'h0005_0401);
    chk("R8 old setting kept", {31'b0, gen_wave_o[3]}, 32'h0);
    repeat (40) @(negedge clk_i);
    chk("R8 new setting applied", {31'b0, gen_wave_o[3]}, 32'h1);

    wr(6, 32'hFC7B_A18F);
    chk("R10 pin held after off", {31'b0, pin_o[2]}, 32'h1);
    chk("R9 reselect immediate", {31'b0, pin_o[0]}, {31'b0, gen_wave_o[7]});
    repeat (300) @(negedge clk_i);
    chk("R10 pin released", {31'b0, pin_o[2]}, 32'h0);
    chk("R12 raw wave still runs", {31'b0, gen_wave_o[1]}, 32'h1);

    repeat (50) @(negedge clk_i);
    live = 0;
    finish_run();
  end
endmodule